// File: doc/BRIEF.md
# Shared-Bus Accumulator Processor

This block is a small stored-program processor. All transfers between its units pass over one 8-bit internal bus. The units are a 4-bit program counter, a memory address register, 16 bytes of RAM, an instruction register, an accumulator A, an operand register B, an add/subtract unit and an output register. In each clock cycle at most one unit drives the bus, and any number of units may latch from it. A control sequencer walks every instruction through five fixed microsteps.

- Steps 0 and 1 are the fetch, and they are the same for every opcode. Step 0 moves the PC into the address register. Step 1 moves the addressed byte into the instruction register and increments the PC.
- Steps 2 to 4 carry out the decoded opcode.

RAM is loaded from outside through a load port while the processor is held in reset. After reset is released, the program runs from address 0. Its results appear on the output register, and a halted flag reports when it has stopped.

Top module: `accum_cpu`

## Requirements
- R1: While `rst` is high at a clock edge, the output register, A, B, the PC, the instruction register and the step counter are cleared, and `halted` goes low. RAM keeps its contents. After reset is released, execution starts again from address 0.
- R2: Each instruction byte holds its opcode in bits 7:4 and its operand n in bits 3:0. The encodings are LDI=0001, ADD=0010, SUB=0011, STA=0100, JMP=0110, OUT=1110 and HALT=1111.
- R3: LDI n loads n into A, zero-extended to 8 bits.
- R4: ADD n reads RAM cell n into B, then sets A to A+B modulo 256.
- R5: SUB n reads RAM cell n into B, then sets A to A+(~B)+1 modulo 256, using the same adder. The carry out of bit 7 is dropped, so 0−1 gives 0xFF.
- R6: STA n writes A into RAM cell n. Code and data share the same 16 cells, so a store into a cell holding code changes the instruction that is fetched from it later.
- R7: OUT copies A into the output register `outVal`. No other instruction changes `outVal`.
- R8: JMP n loads n into the PC, so the next fetch reads cell n.
- R9: The PC has its own incrementer and wraps from 15 to 0. After the instruction in cell 15, the instruction in cell 0 runs.
- R10: HALT sets `halted`. The flag stays set and the output register stays frozen until the next reset.
- R11: Any opcode not listed in R2 runs as a no-operation taking five cycles.
- R12: Each instruction takes exactly five cycles, and at most one unit drives the bus in any cycle. Take the first edge with `rst` low as edge 1, and number instructions i = 0, 1, 2 … in the order they run.
  - If instruction i is an OUT, `outVal` takes its new value at edge 5i+3.
  - If instruction i is a HALT, `halted` rises at edge 5i+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ldEn | input | 1 | Write enable for the RAM load port |
| ldAddr | input | 4 | RAM cell written by the load port |
| ldData | input | 8 | Byte written by the load port |
| outVal | output | 8 | Output register contents |
| halted | output | 1 | High once a HALT has executed |

## Verification
Several corner cases are targeted directly.
- **Subtraction underflow (0−1).** This checks that B is negated in two's complement. A design that only inverts B would give 0xFE.
- **Wrap of the program counter.** A self-modifying program only reaches its OUT if fetching continues at cell 0 after cell 15. A counter that saturates, or that reads a stray fifth bit, would hang until the watchdog fires.
- **Store into code.** This checks that code and data share one memory. A design with separate paths would fetch the stale byte.
- **Jumps, undefined opcodes and reset mid-program.** Jumps must skip the cells they pass over. Undefined opcodes must leave A alone. A reset in the middle of a program must restart execution at address 0.
- **Cycle timing.** Every program's `outVal` trace and its `halted` edge are compared cycle by cycle against a reference model. A microstep sequence that is too short or too long shows up there as a timing mismatch.

// File: rtl/accum_cpu_pkg.sv
package accum_cpu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_LDI = 4'b0001,
    OP_ADD = 4'b0010,
    OP_SUB = 4'b0011,
    OP_STA = 4'b0100,
    OP_JMP = 4'b0110,
    OP_OUT = 4'b1110,
    OP_HLT = 4'b1111
  } opcode_e;

  // Control strobes: the first five drive the bus, the rest latch or steer.
  typedef struct packed {
    logic pcOut;
    logic ramOut;
    logic irOut;
    logic accOut;
    logic aluOut;
    logic marIn;
    logic ramIn;
    logic irIn;
    logic accIn;
    logic opbIn;
    logic outIn;
    logic pcLoad;
    logic pcInc;
    logic aluSub;
  } strobe_t;

endpackage

// File: rtl/accum_cpu_alu.sv
module accum_cpu_alu #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] opbIn,
  input  logic              subEn,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] addend;

  // Subtraction goes through the same adder: the second operand is negated in two's complement.
  always_comb begin
    addend = subEn ? (~opbIn + DATA_W'(1)) : opbIn;
    result = accIn + addend;
  end
endmodule

// File: rtl/accum_cpu_dpath.sv
module accum_cpu_dpath
  import accum_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic              ldEn,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [DATA_W-1:0] ldData,
  output logic [OP_W-1:0]   opField,
  output logic [ADDR_W-1:0] pcVal,
  output logic [DATA_W-1:0] outVal
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] pcQ, marQ;
  logic [DATA_W-1:0] irQ, accQ, opbQ, outQ;
  logic [DATA_W-1:0] aluRes, ramRd, bus;

  accum_cpu_alu #(.DATA_W(DATA_W)) uAlu (
    .accIn (accQ),
    .opbIn (opbQ),
    .subEn (strb.aluSub),
    .result(aluRes)
  );

  assign ramRd = mem[marQ];

  // Shared bus: each source is gated by its own output enable.
  always_comb begin
    bus = '0;
    if (strb.pcOut)  bus = bus | DATA_W'(pcQ);
    if (strb.ramOut) bus = bus | ramRd;
    if (strb.irOut)  bus = bus | DATA_W'(irQ[ADDR_W-1:0]);
    if (strb.accOut) bus = bus | accQ;
    if (strb.aluOut) bus = bus | aluRes;
  end

  always_ff @(posedge clk) begin
    if (ldEn) mem[ldAddr] <= ldData;
    else if (strb.ramIn) mem[marQ] <= bus;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ  <= '0;
      marQ <= '0;
      irQ  <= '0;
      accQ <= '0;
      opbQ <= '0;
      outQ <= '0;
    end else begin
      if (strb.pcLoad)     pcQ <= bus[ADDR_W-1:0];
      else if (strb.pcInc) pcQ <= pcQ + ADDR_W'(1);
      if (strb.marIn) marQ <= bus[ADDR_W-1:0];
      if (strb.irIn)  irQ  <= bus;
      if (strb.accIn) accQ <= bus;
      if (strb.opbIn) opbQ <= bus;
      if (strb.outIn) outQ <= bus;
    end
  end

  assign opField = irQ[DATA_W-1 -: OP_W];
  assign pcVal   = pcQ;
  assign outVal  = outQ;
endmodule

// File: rtl/accum_cpu_ctrl.sv
module accum_cpu_ctrl
  import accum_cpu_pkg::*;
#(
  parameter int STEPS = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opField,
  output strobe_t         strb,
  output logic            halted
);
  localparam int STEP_W = $clog2(STEPS);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);
  localparam logic [STEP_W-1:0] T0 = STEP_W'(0);
  localparam logic [STEP_W-1:0] T1 = STEP_W'(1);
  localparam logic [STEP_W-1:0] T2 = STEP_W'(2);
  localparam logic [STEP_W-1:0] T3 = STEP_W'(3);
  localparam logic [STEP_W-1:0] T4 = STEP_W'(4);

  logic [STEP_W-1:0] stepQ;
  logic              haltQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      stepQ <= '0;
      haltQ <= 1'b0;
    end else if (!haltQ) begin
      stepQ <= (stepQ == LAST) ? '0 : stepQ + STEP_W'(1);
      if (stepQ == T2 && opField == OP_HLT) haltQ <= 1'b1;
    end
  end

  always_comb begin
    strb = '0;
    if (!haltQ) begin
      unique case (stepQ)
        T0: begin strb.pcOut = 1'b1; strb.marIn = 1'b1; end
        T1: begin strb.ramOut = 1'b1; strb.irIn = 1'b1; strb.pcInc = 1'b1; end
        T2: begin
          case (opField)
            OP_LDI: begin strb.irOut = 1'b1; strb.accIn = 1'b1; end
            OP_ADD, OP_SUB, OP_STA: begin strb.irOut = 1'b1; strb.marIn = 1'b1; end
            OP_OUT: begin strb.accOut = 1'b1; strb.outIn = 1'b1; end
            OP_JMP: begin strb.irOut = 1'b1; strb.pcLoad = 1'b1; end
            default: ;
          endcase
        end
        T3: begin
          case (opField)
            OP_ADD, OP_SUB: begin strb.ramOut = 1'b1; strb.opbIn = 1'b1; end
            OP_STA: begin strb.accOut = 1'b1; strb.ramIn = 1'b1; end
            default: ;
          endcase
        end
        T4: begin
          if (opField == OP_ADD || opField == OP_SUB) begin
            strb.aluOut = 1'b1;
            strb.accIn  = 1'b1;
            strb.aluSub = (opField == OP_SUB);
          end
        end
        default: ;
      endcase
    end
  end

  assign halted = haltQ;
endmodule

// File: rtl/accum_cpu.sv
module accum_cpu
  import accum_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int STEPS  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ldEn,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [DATA_W-1:0] ldData,
  output logic [DATA_W-1:0] outVal,
  output logic              halted
);
  strobe_t           strb;
  logic [OP_W-1:0]   opField;
  logic [ADDR_W-1:0] pcVal;

  accum_cpu_ctrl #(.STEPS(STEPS)) uCtrl (
    .clk    (clk),
    .rst    (rst),
    .opField(opField),
    .strb   (strb),
    .halted (halted)
  );

  accum_cpu_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uDpath (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .ldEn   (ldEn),
    .ldAddr (ldAddr),
    .ldData (ldData),
    .opField(opField),
    .pcVal  (pcVal),
    .outVal (outVal)
  );
endmodule

// File: rtl/accum_cpu_chk.sv
module accum_cpu_chk
  import accum_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input strobe_t           strb,
  input logic [ADDR_W-1:0] pcVal,
  input logic [DATA_W-1:0] outVal,
  input logic              halted
);
  assert_bus_onehot_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.pcOut, strb.ramOut, strb.irOut, strb.accOut, strb.aluOut}))
    else $error("bus contention");

  assert_pc_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (strb.pcInc && !strb.pcLoad) |=> pcVal == ADDR_W'($past(pcVal) + 1'b1))
    else $error("pc increment wrong");

  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted)
    else $error("halt dropped");

  assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    halted |-> strb == '0)
    else $error("strobes while halted");

  assert_out_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !strb.outIn |=> $stable(outVal))
    else $error("output changed without OUT");

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (outVal == '0 && !halted))
    else $error("reset did not clear");
endmodule

bind accum_cpu accum_cpu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uChk (
  .clk   (clk),
  .rst   (rst),
  .strb  (strb),
  .pcVal (pcVal),
  .outVal(outVal),
  .halted(halted)
);

// File: tb/accum_cpu_test.sv
module accum_cpu_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_INSTR  = 60;
  localparam int MAX_EDGE   = MAX_INSTR * 5 + 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ldEn = 1'b0;
  logic [3:0] ldAddr = '0;
  logic [7:0] ldData = '0;
  logic [7:0] outVal;
  logic       halted;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  logic [7:0] prog [16];
  logic [7:0] expOut [MAX_EDGE + 1];
  int         expHaltEdge;

  accum_cpu uut (
    .clk(clk), .rst(rst), .ldEn(ldEn), .ldAddr(ldAddr), .ldData(ldData),
    .outVal(outVal), .halted(halted)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Reference model: instruction i spans edges 5i+1..5i+5, OUT and HALT act at 5i+3.
  task automatic runIss();
    logic [7:0] m [16];
    logic [7:0] a, b, o, oldO;
    logic [3:0] pc, n, op;
    int count;
    bit h;
    m = prog; a = '0; o = '0; pc = '0; h = 1'b0; count = 0;
    expHaltEdge = -1;
    expOut[0] = '0;
    for (int i = 0; i < MAX_INSTR && !h; i++) begin
      op = m[pc][7:4]; n = m[pc][3:0]; pc = pc + 4'd1; oldO = o;
      case (op)
        4'b0001: a = {4'b0, n};
        4'b0010: begin b = m[n]; a = a + b; end
        4'b0011: begin b = m[n]; a = a + ~b + 8'd1; end
        4'b0100: m[n] = a;
        4'b0110: pc = n;
        4'b1110: o = a;
        4'b1111: begin h = 1'b1; expHaltEdge = 5 * i + 3; end
        default: ;
      endcase
      expOut[5*i+1] = oldO; expOut[5*i+2] = oldO;
      expOut[5*i+3] = o; expOut[5*i+4] = o; expOut[5*i+5] = o;
      count = i + 1;
    end
    for (int e = 5 * count + 1; e <= MAX_EDGE; e++) expOut[e] = o;
  endtask

  task automatic loadAndReset();
    rst = 1'b1;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); ldEn = 1'b1; ldAddr = 4'(k); ldData = prog[k];
    end
    @(negedge clk); ldEn = 1'b0;
    @(negedge clk);
    check(outVal == 8'h00, "R1 reset clears output", int'(outVal), 0);
    check(halted == 1'b0, "R1 reset clears halted", int'(halted), 0);
    rst = 1'b0;
  endtask

  task automatic runProgram(input string tag);
    int badEdge, badAct, haltBad;
    runIss();
    loadAndReset();
    badEdge = -1; badAct = 0; haltBad = -1;
    for (int e = 1; e <= expHaltEdge + 10; e++) begin
      @(posedge clk); @(negedge clk);
      if (badEdge < 0 && outVal !== expOut[e]) begin badEdge = e; badAct = int'(outVal); end
      if (haltBad < 0 && halted !== (e >= expHaltEdge)) haltBad = e;
    end
    check(badEdge < 0, {tag, " R7 output trace"}, badAct,
          (badEdge < 0) ? 0 : int'(expOut[badEdge]));
    check(haltBad < 0, {tag, " R12/R10 halt timing and hold"}, haltBad, -1);
    check(outVal == expOut[MAX_EDGE], {tag, " final output"}, int'(outVal),
          int'(expOut[MAX_EDGE]));
  endtask

  task automatic clearProg();
    for (int k = 0; k < 16; k++) prog[k] = 8'hF0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    bit halts;
    void'($urandom(32'd20240611));

    // R3 R2: LDI then OUT
    clearProg(); prog[0] = 8'h15; prog[1] = 8'hE0; prog[2] = 8'hF0;
    runProgram("R3 LDI/OUT");

    // R4 R5: add and subtract from data cells
    clearProg(); prog[0] = 8'h13; prog[1] = 8'h2E; prog[2] = 8'h3F; prog[3] = 8'hE0;
    prog[14] = 8'd200; prog[15] = 8'd7;
    runProgram("R4 R5 add/sub");

    // R5: 0 - 1 gives 0xFF
    clearProg(); prog[0] = 8'h10; prog[1] = 8'h3F; prog[2] = 8'hE0; prog[15] = 8'd1;
    runProgram("R5 underflow");
    check(outVal == 8'hFF, "R5 0-1 is FF", int'(outVal), 8'hFF);

    // R4: overflow drops carry, 15+250 = 9
    clearProg(); prog[0] = 8'h1F; prog[1] = 8'h2E; prog[2] = 8'hE0; prog[14] = 8'd250;
    runProgram("R4 overflow");
    check(outVal == 8'h09, "R4 carry dropped", int'(outVal), 9);

    // R6: store data then add it back, and store over code
    clearProg(); prog[0] = 8'h19; prog[1] = 8'h4D; prog[2] = 8'h11; prog[3] = 8'h2D;
    prog[4] = 8'hE0;
    runProgram("R6 store/reload");
    check(outVal == 8'd10, "R6 stored value reused", int'(outVal), 10);
    clearProg(); prog[0] = 8'h1F; prog[1] = 8'h43; prog[2] = 8'hE0; prog[3] = 8'hF0;
    prog[4] = 8'h12; prog[5] = 8'hE0; prog[6] = 8'hF0;
    runProgram("R6 self-modify");
    check(outVal == 8'd2, "R6 overwritten HALT skipped", int'(outVal), 2);

    // R8: jump over cells
    clearProg(); prog[0] = 8'h14; prog[1] = 8'h64; prog[2] = 8'h17; prog[3] = 8'hF0;
    prog[4] = 8'hE0; prog[5] = 8'hF0;
    runProgram("R8 jump");
    check(outVal == 8'd4, "R8 skipped cell 2", int'(outVal), 4);

    // R9 R11: wrap from 15 to 0 into a cell rewritten to a no-op
    clearProg(); prog[0] = 8'h6E; prog[1] = 8'hE0; prog[2] = 8'hF0;
    prog[14] = 8'h1F; prog[15] = 8'h40;
    runProgram("R9 wrap");
    check(outVal == 8'd15, "R9 wrap reached cell 1", int'(outVal), 15);

    // R11: undefined opcodes leave A alone
    clearProg(); prog[0] = 8'h13; prog[1] = 8'h57; prog[2] = 8'h8A; prog[3] = 8'hD1;
    prog[4] = 8'h0C; prog[5] = 8'hE0;
    runProgram("R11 no-op");
    check(outVal == 8'd3, "R11 A unchanged", int'(outVal), 3);

    // R1 R12: reset mid-program restarts from address 0
    clearProg(); prog[0] = 8'h19; prog[1] = 8'hE0; prog[2] = 8'h62;
    loadAndReset();
    repeat (20) begin @(posedge clk); end
    @(negedge clk);
    check(outVal == 8'd9 && !halted, "R1 running loop", int'(outVal), 9);
    rst = 1'b1; @(posedge clk); @(negedge clk);
    check(outVal == 8'd0 && !halted, "R1 mid-run reset", int'(outVal), 0);
    rst = 1'b0;
    repeat (7) begin @(posedge clk); end
    @(negedge clk);
    check(outVal == 8'd0, "R12 OUT not before edge 8", int'(outVal), 0);
    @(posedge clk); @(negedge clk);
    check(outVal == 8'd9, "R1 R12 restart OUT at edge 8", int'(outVal), 9);

    // Constrained random programs (R2 encodings)
    for (int p = 0; p < 20; p++) begin
      halts = 1'b0;
      for (int tries = 0; tries < 50 && !halts; tries++) begin
        for (int k = 0; k < 16; k++) begin
          logic [3:0] opPick;
          case ($urandom % 8)
            0: opPick = 4'b0001; 1: opPick = 4'b0010; 2: opPick = 4'b0011;
            3: opPick = 4'b0100; 4: opPick = 4'b1110; 5: opPick = 4'b0110;
            6: opPick = 4'b1111; default: opPick = 4'b1001;
          endcase
          prog[k] = {opPick, 4'($urandom)};
        end
        runIss();
        halts = (expHaltEdge > 0);
      end
      if (!halts) begin prog[0] = 8'hF0; end
      runProgram("R2 random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule